// File: doc/BRIEF.md
# Byte-to-Word Peripheral Bus Bridge

This block lets an 8-bit processor bus reach devices on an external 16-bit I/O bus. The external bus has separate active-low read and write strobes. The processor sees a 256-byte window. The two top offset bits pick one of four device regions of 64 bytes each, and each region drives its own select line. In the lowest region, offset bit 4 further picks one of two sub-selects. Offset bits 5:1 form the 5-bit word address on the external bus. Offset bit 0 picks the byte lane. An even offset is the high byte (bus bits 15:8) and an odd offset is the low byte (bus bits 7:0).

Software moves a 16-bit word as two byte accesses, even offset first. Reading the even byte runs a bus read and keeps the whole word. The odd byte that follows is then served from that stored word. Writing the even byte only stores it. Writing the odd byte sends the full word out in a single strobed bus write. Each bus transfer keeps its strobe active for a fixed number of wait states, and the processor is stalled meanwhile.

The processor side is a request bus with back-pressure. The processor presents `cs`, `rw`, `addr` and `wdata` and keeps them steady while `hold` is high. An access is accepted and completes in the first cycle in which `cs` is high and `hold` is low. Read data is valid on `rdata` in that same cycle. Between accesses the processor drops `cs` for at least one cycle.

Top module: `pbus_bridge`

## Requirements
- R1: After reset, `hold` is low, both strobes are high, all device selects and sub-selects are zero, and the bridge does not drive the data bus.
- R2: Offset bits 7:6 choose the device region. Exactly the matching `dev_sel` bit (bit n for region n) is high, and only while a strobe is low.
- R3: In region 0, `sub_sel[0]` is high when offset bit 4 is 0 and `sub_sel[1]` when it is 1. For the other regions `sub_sel` stays zero.
- R4: During a bus transfer, `bus_addr` equals offset bits 5:1 and does not change while the strobe is low.
- R5: Offset bit 0 picks the lane. 0 means bus bits 15:8 and 1 means bus bits 7:0.
- R6: A read of an even offset raises `hold` in the cycle `cs` arrives. `bus_rd_n` is then low for exactly WAITS (default 4) cycles. `hold` is low in the cycle after the last strobe cycle, and `rdata` then shows bits 15:8 of the word sampled on that edge. `hold` stays high for WAITS+1 cycles in total.
- R7: A read of an odd offset completes with `hold` low, starts no bus transfer, and returns bits 7:0 of the last word read from the bus (zero after reset).
- R8: A write of an even offset completes with `hold` low, starts no bus transfer, and leaves the stored read word unchanged.
- R9: A write of an odd offset stalls like R6 with `bus_wr_n` low for exactly WAITS cycles. During that time the bus carries the last even-offset write data in bits 15:8 and this write's data in bits 7:0.
- R10: The bridge releases the data bus whenever `bus_wr_n` is high.
- R11: `bus_rd_n` and `bus_wr_n` are never low in the same cycle.
- R12: The completion cycle of a bus transfer never starts another transfer, even though `cs` is still high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Processor access request for the window |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 8 | Offset in the 256-byte window |
| wdata | input | 8 | Processor write byte |
| rdata | output | 8 | Processor read byte |
| hold | output | 1 | Stall request to the processor |
| bus_rd_n | output | 1 | External read strobe, active low |
| bus_wr_n | output | 1 | External write strobe, active low |
| bus_addr | output | 5 | External word address |
| bus_data | inout | 16 | External data bus |
| dev_sel | output | 4 | Device region selects, active high |
| sub_sel | output | 2 | Region 0 sub-selects, active high |

## Verification
A sequencer that is stuck or out of step shows up on the strobes within one access. It can give a strobe length other than WAITS, a second pulse after the completion cycle, or `hold` falling while a strobe is still low. A corrupted high-byte store or read-word store only appears at the ports one access later: in the word seen on the bus during the odd-byte write, or in `rdata` on the odd-byte read. For that reason every even access is followed by its odd partner, and reads of the odd byte are also checked after writes. Decode faults appear at once on `dev_sel`, `sub_sel` and `bus_addr` during the strobe, and a sweep of every offset in the window exposes them.

// File: rtl/pbb_pkg.sv
package pbb_pkg;

  typedef enum logic [1:0] {
    PB_IDLE = 2'd0,
    PB_RUN  = 2'd1,
    PB_DONE = 2'd2
  } pb_state_t;

endpackage

// File: rtl/pbb_decode.sv
module pbb_decode #(
  parameter int CPU_AW = 8,
  parameter int N_DEV  = 4
) (
  input  logic [CPU_AW-1:0]                  addr,
  output logic [N_DEV-1:0]                   dev_hot,
  output logic [1:0]                         sub_hot,
  output logic [CPU_AW-$clog2(N_DEV)-2:0]    word_addr,
  output logic                               lane_hi
);
  localparam int DEV_W   = $clog2(N_DEV);
  localparam int REG_AW  = CPU_AW - DEV_W;
  localparam int SUB_BIT = REG_AW - 2;

  logic [DEV_W-1:0] region;

  assign region    = addr[CPU_AW-1 -: DEV_W];
  assign word_addr = addr[REG_AW-1:1];
  assign lane_hi   = ~addr[0];

  for (genvar g = 0; g < N_DEV; g++) begin : g_dev
    assign dev_hot[g] = (region == DEV_W'(g));
  end

  assign sub_hot[0] = dev_hot[0] & ~addr[SUB_BIT];
  assign sub_hot[1] = dev_hot[0] &  addr[SUB_BIT];

endmodule

// File: rtl/pbb_wait.sv
module pbb_wait #(
  parameter int WAITS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic last
);
  localparam int CW = $clog2(WAITS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(WAITS - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/pbb_lane.sv
module pbb_lane #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                store_hi,
  input  logic                load_wr,
  input  logic                cap_rd,
  input  logic                lane_hi,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic [2*BYTE_W-1:0] bus_in,
  output logic [2*BYTE_W-1:0] wr_word,
  output logic [BYTE_W-1:0]   rdata
);
  logic [BYTE_W-1:0]   hi_q;
  logic [2*BYTE_W-1:0] rd_word_q;
  logic [2*BYTE_W-1:0] wr_word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q      <= '0;
      rd_word_q <= '0;
      wr_word_q <= '0;
    end else begin
      if (store_hi) hi_q      <= wdata;
      if (load_wr)  wr_word_q <= {hi_q, wdata};
      if (cap_rd)   rd_word_q <= bus_in;
    end
  end

  assign wr_word = wr_word_q;
  assign rdata   = lane_hi ? rd_word_q[2*BYTE_W-1:BYTE_W] : rd_word_q[BYTE_W-1:0];

endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
  import pbb_pkg::*;
#(
  parameter int CPU_AW = 8,
  parameter int BYTE_W = 8,
  parameter int N_DEV  = 4,
  parameter int WAITS  = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cs,
  input  logic                                rw,
  input  logic [CPU_AW-1:0]                   addr,
  input  logic [BYTE_W-1:0]                   wdata,
  output logic [BYTE_W-1:0]                   rdata,
  output logic                                hold,
  output logic                                bus_rd_n,
  output logic                                bus_wr_n,
  output logic [CPU_AW-$clog2(N_DEV)-2:0]     bus_addr,
  inout  wire  [2*BYTE_W-1:0]                 bus_data,
  output logic [N_DEV-1:0]                    dev_sel,
  output logic [1:0]                          sub_sel
);
  localparam int DEV_W  = $clog2(N_DEV);
  localparam int BUS_AW = CPU_AW - DEV_W - 1;
  localparam int WORD_W = 2 * BYTE_W;

  pb_state_t state_q;
  logic              dir_wr_q;
  logic [BUS_AW-1:0] addr_q;
  logic [N_DEV-1:0]  sel_q;
  logic [1:0]        sub_q;

  logic [N_DEV-1:0]  dec_dev;
  logic [1:0]        dec_sub;
  logic [BUS_AW-1:0] dec_waddr;
  logic              lane_hi;
  logic              idle_req;
  logic              launch;
  logic              store_hi;
  logic              run;
  logic              wt_last;
  logic              cap_rd;
  logic [WORD_W-1:0] wr_word;

  pbb_decode #(.CPU_AW(CPU_AW), .N_DEV(N_DEV)) u_decode (
    .addr      (addr),
    .dev_hot   (dec_dev),
    .sub_hot   (dec_sub),
    .word_addr (dec_waddr),
    .lane_hi   (lane_hi)
  );

  assign idle_req = (state_q == PB_IDLE) & cs;
  assign launch   = idle_req & ((rw & lane_hi) | (~rw & ~lane_hi));
  assign store_hi = idle_req & ~rw & lane_hi;
  assign run      = (state_q == PB_RUN);

  pbb_wait #(.WAITS(WAITS)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .start (launch),
    .last  (wt_last)
  );

  assign cap_rd = run & wt_last & ~dir_wr_q;

  pbb_lane #(.BYTE_W(BYTE_W)) u_lane (
    .clk      (clk),
    .rst_n    (rst_n),
    .store_hi (store_hi),
    .load_wr  (launch & ~rw),
    .cap_rd   (cap_rd),
    .lane_hi  (lane_hi),
    .wdata    (wdata),
    .bus_in   (bus_data),
    .wr_word  (wr_word),
    .rdata    (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PB_IDLE;
      dir_wr_q <= 1'b0;
      addr_q   <= '0;
      sel_q    <= '0;
      sub_q    <= '0;
    end else begin
      case (state_q)
        PB_IDLE: begin
          if (launch) begin
            state_q  <= PB_RUN;
            dir_wr_q <= ~rw;
            addr_q   <= dec_waddr;
            sel_q    <= dec_dev;
            sub_q    <= dec_sub;
          end
        end
        PB_RUN: begin
          if (wt_last) state_q <= PB_DONE;
        end
        PB_DONE: state_q <= PB_IDLE;
        default: state_q <= PB_IDLE;
      endcase
    end
  end

  assign hold     = launch | run;
  assign bus_rd_n = ~(run & ~dir_wr_q);
  assign bus_wr_n = ~(run & dir_wr_q);
  assign bus_addr = addr_q;
  assign dev_sel  = run ? sel_q : '0;
  assign sub_sel  = run ? sub_q : '0;
  assign bus_data = (run & dir_wr_q) ? wr_word : 'z;

endmodule

// File: rtl/pbus_bridge_chk.sv
module pbus_bridge_chk #(
  parameter int N_DEV  = 4,
  parameter int BUS_AW = 5,
  parameter int WAITS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [N_DEV-1:0]  dev_sel,
  input logic [1:0]        sub_sel
);
  logic        strobe;
  logic [15:0] len_q;

  assign strobe = ~bus_rd_n | ~bus_wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else        len_q <= strobe ? len_q + 1'b1 : '0;
  end

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(~bus_rd_n & ~bus_wr_n));

  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_sel));

  assert_sel_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((dev_sel != '0) == strobe));

  assert_sub_region0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_sel != 2'b00) |-> (dev_sel[0] && $onehot(sub_sel)));

  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe)) |-> $stable(bus_addr));

  assert_strobe_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> (len_q == 16'(WAITS)));

  assert_strobe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> hold);

  assert_hold_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $past(strobe));

  assert_no_relaunch_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |=> !strobe);

endmodule

bind pbus_bridge pbus_bridge_chk #(
  .N_DEV  (N_DEV),
  .BUS_AW (CPU_AW - $clog2(N_DEV) - 1),
  .WAITS  (WAITS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hold     (hold),
  .bus_rd_n (bus_rd_n),
  .bus_wr_n (bus_wr_n),
  .bus_addr (bus_addr),
  .dev_sel  (dev_sel),
  .sub_sel  (sub_sel)
);

// File: tb/pbus_bridge_bench.sv
module pbus_bridge_bench;
  localparam int          CLK_PERIOD = 10;
  localparam int          WAITS      = 4;
  localparam logic [15:0] PROBE      = 16'hC35A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0;
  logic        rw = 1'b1;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        hold;
  logic        bus_rd_n;
  logic        bus_wr_n;
  logic [4:0]  bus_addr;
  wire  [15:0] bus_data;
  logic [3:0]  dev_sel;
  logic [1:0]  sub_sel;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbus_bridge u_pbus_bridge (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rw(rw), .addr(addr), .wdata(wdata),
    .rdata(rdata), .hold(hold), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_data(bus_data), .dev_sel(dev_sel), .sub_sel(sub_sel)
  );

  // responder: word built from region and word address
  logic [1:0]  resp_reg;
  logic [15:0] resp_word;
  always_comb begin
    resp_reg = 2'd0;
    for (int i = 0; i < 4; i++) if (dev_sel[i]) resp_reg = 2'(i);
    resp_word = {3'b101, bus_addr, ~bus_addr, resp_reg, 1'b1};
  end
  assign bus_data = !bus_rd_n ? resp_word : (bus_wr_n ? PROBE : 16'hzzzz);

  function automatic logic [15:0] exp_word(input logic [7:0] a);
    return {3'b101, a[5:1], ~a[5:1], a[7:6], 1'b1};
  endfunction

  // strobe monitor
  int          rd_pulses = 0, wr_pulses = 0, rd_len = 0, wr_len = 0;
  bit          rd_act = 0, wr_act = 0;
  logic [4:0]  cap_addr;
  logic [3:0]  cap_sel;
  logic [1:0]  cap_sub;
  logic [15:0] cap_wword;
  always @(negedge clk) begin
    if (!bus_rd_n) begin
      if (!rd_act) begin
        rd_pulses++; rd_len = 0;
        cap_addr = bus_addr; cap_sel = dev_sel; cap_sub = sub_sel;
      end
      rd_len++;
    end
    if (!bus_wr_n) begin
      if (!wr_act) begin
        wr_pulses++; wr_len = 0;
        cap_addr = bus_addr; cap_sel = dev_sel; cap_sub = sub_sel;
        cap_wword = bus_data;
      end
      wr_len++;
    end
    rd_act = !bus_rd_n;
    wr_act = !bus_wr_n;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [7:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int hc);
    cs = 1'b1; rw = !wr; addr = a; wdata = d;
    hc = 0;
    #1;
    while (hold && hc < 50) begin
      hc++;
      @(negedge clk); #1;
    end
    rd = rdata;
    @(negedge clk);
    cs = 1'b0; rw = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(bus_data == PROBE, "R10 released", bus_data, PROBE);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  r;
    logic [15:0] last_rd;
    int hc, rp, wp;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(hold == 1'b0, "R1 hold", hold, 0);
    chk(bus_rd_n && bus_wr_n, "R1 strobes", {bus_rd_n, bus_wr_n}, 2'b11);
    chk(dev_sel == 0 && sub_sel == 0, "R1 selects", {dev_sel, sub_sel}, 0);
    chk(bus_data == PROBE, "R1 released", bus_data, PROBE);
    rst_n = 1'b1;
    @(negedge clk);
    last_rd = 16'h0000;

    for (int a = 0; a < 256; a += 2) begin
      logic [7:0]  ea = 8'(a);
      logic [7:0]  hb = ea ^ 8'h3C;
      logic [7:0]  lb = ~ea;
      logic [1:0]  esub = (ea[7:6] == 2'd0) ? (ea[4] ? 2'b10 : 2'b01) : 2'b00;
      logic [15:0] ew = exp_word(ea);

      // R8: even write is local only
      rp = rd_pulses; wp = wr_pulses;
      access(1'b1, ea, hb, r, hc);
      chk(hc == 0, "R8 hold", 32'(hc), 0);
      chk(rd_pulses == rp && wr_pulses == wp, "R8 no bus",
          32'(wr_pulses - wp), 0);

      // R7/R8: odd read serves stored word, untouched by the write
      access(1'b0, ea | 8'd1, 8'h00, r, hc);
      chk(hc == 0 && rd_pulses == rp, "R7 local read", 32'(hc), 0);
      chk(r == last_rd[7:0], "R7 R8 low byte", r, last_rd[7:0]);

      // R9: odd write sends the full word
      access(1'b1, ea | 8'd1, lb, r, hc);
      chk(hc == WAITS + 1, "R9 hold cycles", 32'(hc), 32'(WAITS + 1));
      chk(wr_pulses == wp + 1 && rd_pulses == rp, "R9 R12 one pulse",
          32'(wr_pulses - wp), 1);
      chk(wr_len == WAITS, "R9 strobe length", 32'(wr_len), 32'(WAITS));
      chk(cap_wword == {hb, lb}, "R9 R5 word", cap_wword, {hb, lb});
      chk(cap_addr == ea[5:1], "R4 address", cap_addr, ea[5:1]);
      chk(cap_sel == 4'(1 << ea[7:6]), "R2 select", cap_sel, 4'(1 << ea[7:6]));
      chk(cap_sub == esub, "R3 sub-select", cap_sub, esub);

      // R6: even read runs a bus cycle
      rp = rd_pulses; wp = wr_pulses;
      access(1'b0, ea, 8'h00, r, hc);
      chk(hc == WAITS + 1, "R6 hold cycles", 32'(hc), 32'(WAITS + 1));
      chk(rd_pulses == rp + 1 && wr_pulses == wp, "R6 R12 one pulse",
          32'(rd_pulses - rp), 1);
      chk(rd_len == WAITS, "R6 strobe length", 32'(rd_len), 32'(WAITS));
      chk(r == ew[15:8], "R6 R5 high byte", r, ew[15:8]);
      chk(cap_addr == ea[5:1], "R4 read address", cap_addr, ea[5:1]);
      chk(cap_sel == 4'(1 << ea[7:6]), "R2 read select", cap_sel, 4'(1 << ea[7:6]));
      chk(cap_sub == esub, "R3 read sub-select", cap_sub, esub);

      // R7: odd read returns low byte of that word
      access(1'b0, ea | 8'd1, 8'h00, r, hc);
      chk(hc == 0 && rd_pulses == rp + 1, "R7 no bus", 32'(hc), 0);
      chk(r == ew[7:0], "R7 R5 low byte", r, ew[7:0]);
      last_rd = ew;
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule